// File: doc/BRIEF.md
# Sample-Rate Tone Parameter Bank Selector

This block stores three banks of tone parameters whose proper values depend on the audio sample rate. Each bank holds five bass filter-set selections and five treble filter-set selections. The block continuously presents the active bank's values to a downstream tone processor. Software programs the banks and a bank-control register through a small synchronous write port with a combinational read-back path.

The active bank is chosen in one of two ways. In manual mode, a two-bit index in the control register selects the bank. In automatic mode, each bank carries an enable mask with one bit per sample-rate code, and the detected rate code picks the bank. Either way, a selection change is applied only on a frame-boundary strobe. In automatic mode it also needs a valid rate indication.

After reset the block is in manual mode with the first bank active, and that bank holds flat defaults. The other two banks hold zeros, so selecting them before they are programmed drives all-zero parameters, which can silence the output.

Top module: `tone_bank_sel`

## Requirements
- R1: After reset the following hold. `active_bank` is 0 (banks are encoded 0, 1 and 2 for banks 1 to 3). The outputs carry the bank-1 defaults `BASS_RST` and `TREB_RST`, each five 4-bit fields of 6 (0x66666). Control (address 0) reads 0x0000FF00, which is manual mode, index 0, bank-1 mask 0xFF and the other masks 0. The parameter registers of banks 2 and 3 read 0.
- R2: A write with `wr_en` high stores `wdata` in the addressed register, and the new value reads back on `rdata` from the next cycle. The parameter addresses are as follows: bass of bank b (b = 0..2) is at 1+2b and treble of bank b is at 2+2b, each occupying bits [19:0].
- R3: `bass_sel` and `treble_sel` always equal the stored bass and treble of the bank named by `active_bank`. A write to the active bank appears on the outputs in the cycle after the write.
- R4: The control register has these fields: bit 0 is the mode (0 manual, 1 auto), bits [2:1] are the manual index, and the mask of bank b is at bits [8+8b +: 8]. Bit r of a mask enables rate code r. The active bank changes only in the cycle after `frame_strobe` is high. In manual mode it then takes the manual index.
- R5: In auto mode, a strobe with `rate_valid` high selects the lowest-numbered bank whose mask bit at `rate_code` is set.
- R6: In auto mode, a valid strobe whose rate code is enabled in no mask selects bank index 0.
- R7: In auto mode, a strobe with `rate_valid` low leaves the active bank unchanged.
- R8: A control write with index field 3 leaves the stored manual index unchanged, while its other fields are still written.
- R9: Selecting a bank that was never programmed drives zero on both parameter outputs.
- R10: A write to address 7 changes no register, and a read of address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| rate_code | input | 3 | Detected sample-rate code |
| rate_valid | input | 1 | Rate code is trustworthy |
| frame_strobe | input | 1 | Frame boundary; selection changes apply here |
| active_bank | output | 2 | Index of the active bank (0..2) |
| bass_sel | output | 20 | Active bank's five bass selections |
| treble_sel | output | 20 | Active bank's five treble selections |

## Verification
Manual selection is tried in two ways. The index is written and then checked before a strobe, which separates immediate switching from strobe-aligned switching. An illegal index of 3 is also written, which shows whether the index field is masked independently of the mask fields.

Automatic selection is tried with overlapping masks, so that rate code 2 is enabled in two banks, which exposes the priority order. A rate code enabled in no mask checks the fallback to bank 1. A strobe with the valid flag low must leave the selection unchanged. Pointing the selector at the unprogrammed third bank separates true zero reset contents from contents carried over from another bank.

// File: rtl/tone_bank_sel.sv
module tone_bank_sel #(
  parameter int NRATE = 8,
  parameter int NSET  = 5,
  parameter int SELW  = 4,
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter logic [NSET*SELW-1:0] BASS_RST = {NSET{4'h6}},
  parameter logic [NSET*SELW-1:0] TREB_RST = {NSET{4'h6}},
  localparam int RW = $clog2(NRATE),
  localparam int PW = NSET*SELW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [RW-1:0] rate_code,
  input  logic          rate_valid,
  input  logic          frame_strobe,
  output logic [1:0]    active_bank,
  output logic [PW-1:0] bass_sel,
  output logic [PW-1:0] treble_sel
);
  localparam int NB = 3;
  localparam int MLSB = 8;

  logic             auto_mode;
  logic [1:0]       man_idx;
  logic [NRATE-1:0] mask [NB];
  logic [PW-1:0]    bass [NB];
  logic [PW-1:0]    treb [NB];
  logic [NB-1:0]    hit;
  logic [1:0]       pick;

  wire ctrl_wr = wr_en && (addr == AW'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_mode <= 1'b0;
      man_idx   <= 2'd0;
    end else if (ctrl_wr) begin
      auto_mode <= wdata[0];
      if (wdata[2:1] != 2'd3) man_idx <= wdata[2:1];
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (!rst_n) begin
        mask[b] <= (b == 0) ? {NRATE{1'b1}} : '0;
        bass[b] <= (b == 0) ? BASS_RST : '0;
        treb[b] <= (b == 0) ? TREB_RST : '0;
      end else if (wr_en) begin
        if (addr == AW'(0)) mask[b] <= wdata[MLSB+b*NRATE +: NRATE];
        if (addr == AW'(1+2*b)) bass[b] <= wdata[PW-1:0];
        if (addr == AW'(2+2*b)) treb[b] <= wdata[PW-1:0];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_hit
      assign hit[g] = mask[g][rate_code];
    end
  endgenerate

  always_comb begin
    pick = 2'd0;
    for (int b = NB-1; b >= 0; b--)
      if (hit[b]) pick = 2'(b);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      active_bank <= 2'd0;
    else if (frame_strobe) begin
      if (!auto_mode)      active_bank <= man_idx;
      else if (rate_valid) active_bank <= pick;
    end
  end

  assign bass_sel   = bass[active_bank];
  assign treble_sel = treb[active_bank];

  always_comb begin
    rdata = '0;
    if (addr == AW'(0)) begin
      rdata[0]   = auto_mode;
      rdata[2:1] = man_idx;
      for (int b = 0; b < NB; b++) rdata[MLSB+b*NRATE +: NRATE] = mask[b];
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (addr == AW'(1+2*b)) rdata[PW-1:0] = bass[b];
        if (addr == AW'(2+2*b)) rdata[PW-1:0] = treb[b];
      end
    end
  end
endmodule

// File: rtl/tone_bank_sel_chk.sv
module tone_bank_sel_chk #(
  parameter int NRATE = 8,
  parameter int RW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_strobe,
  input logic             rate_valid,
  input logic [RW-1:0]    rate_code,
  input logic [1:0]       active_bank,
  input logic             auto_mode,
  input logic [1:0]       man_idx,
  input logic [3*NRATE-1:0] masks
);
  wire any_hit = |{masks[2*NRATE + rate_code], masks[NRATE + rate_code], masks[rate_code]};

  p_bank_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active_bank != 2'd3);

  p_hold_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(active_bank));

  p_manual_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !auto_mode) |=> active_bank == $past(man_idx));

  p_nomatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && auto_mode && rate_valid && !any_hit) |=> active_bank == 2'd0);

  p_invalid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && auto_mode && !rate_valid) |=> $stable(active_bank));

  p_idx_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    man_idx != 2'd3);
endmodule

bind tone_bank_sel tone_bank_sel_chk #(.NRATE(NRATE), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .rate_valid(rate_valid),
  .rate_code(rate_code), .active_bank(active_bank), .auto_mode(auto_mode),
  .man_idx(man_idx), .masks({mask[2], mask[1], mask[0]})
);

// File: tb/tone_bank_sel_test.sv
module tone_bank_sel_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rate_valid = 0, frame_strobe = 0;
  logic [2:0] addr = 0, rate_code = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0] active_bank;
  logic [19:0] bass_sel, treble_sel;

  always #2.5 clk = ~clk;

  tone_bank_sel uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rate_code(rate_code), .rate_valid(rate_valid), .frame_strobe(frame_strobe),
    .active_bank(active_bank), .bass_sel(bass_sel), .treble_sel(treble_sel)
  );

  typedef struct {
    bit          is_rd;
    logic [31:0] a;
    logic [19:0] b;
    logic [19:0] c;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.is_rd) begin
        if (rdata !== it.a) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.a);
        end
      end else if (active_bank !== it.a[1:0] || bass_sel !== it.b || treble_sel !== it.c) begin
        errors++;
        $display("FAIL %s: bank/bass/treble actual %0d %h %h expected %0d %h %h",
                 it.tag, active_bank, bass_sel, treble_sel, it.a[1:0], it.b, it.c);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic strobe(input logic [2:0] rc, input logic v);
    @(negedge clk); rate_code = rc; rate_valid = v; frame_strobe = 1;
    @(negedge clk); frame_strobe = 0;
  endtask

  task automatic exp_out(input logic [1:0] bk, input logic [19:0] b, input logic [19:0] t, input string tag);
    item_t it;
    it.is_rd = 0; it.a = {30'd0, bk}; it.b = b; it.c = t; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] v, input string tag);
    item_t it;
    addr = a;
    it.is_rd = 1; it.a = v; it.b = 0; it.c = 0; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  localparam logic [19:0] DEF = 20'h66666;

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    exp_out(0, DEF, DEF, "R1 reset outputs");
    exp_rd(0, 32'h0000FF00, "R1 reset control");
    exp_rd(3, 0, "R1 bank2 bass zero");
    exp_rd(6, 0, "R1 bank3 treble zero");

    wr(3, 32'h00012345);
    wr(4, 32'h000ABCDE);
    exp_rd(3, 32'h00012345, "R2 bank2 bass readback");
    exp_rd(4, 32'h000ABCDE, "R2 bank2 treble readback");
    wr(1, 32'h00011111);
    exp_out(0, 20'h11111, DEF, "R3 active bank write visible");

    wr(0, 32'h0000FF02);
    exp_out(0, 20'h11111, DEF, "R4 no switch before strobe");
    strobe(0, 0);
    exp_out(1, 20'h12345, 20'hABCDE, "R4 manual switch on strobe");

    wr(0, 32'h0001FF06);
    exp_rd(0, 32'h0001FF02, "R8 illegal index kept, mask written");
    strobe(0, 0);
    exp_out(1, 20'h12345, 20'hABCDE, "R8 selection kept");

    wr(0, 32'h0000FF04);
    strobe(0, 0);
    exp_out(2, 0, 0, "R9 unprogrammed bank gives zeros");

    wr(0, 32'h04060101);
    exp_out(2, 0, 0, "R4 auto mode waits for strobe");
    strobe(2, 1);
    exp_out(1, 20'h12345, 20'hABCDE, "R5 lowest matching bank wins");
    strobe(0, 1);
    exp_out(0, 20'h11111, DEF, "R5 rate0 selects bank1");
    strobe(1, 1);
    exp_out(1, 20'h12345, 20'hABCDE, "R5 rate1 selects bank2");
    strobe(5, 1);
    exp_out(0, 20'h11111, DEF, "R6 no match falls back");
    strobe(1, 1);
    strobe(0, 0);
    exp_out(1, 20'h12345, 20'hABCDE, "R7 invalid rate holds");

    wr(0, 32'h0C060101);
    strobe(3, 1);
    exp_out(2, 0, 0, "R5 rate3 selects bank3");

    wr(7, 32'hFFFFFFFF);
    exp_rd(0, 32'h0C060101, "R10 unmapped write leaves control");
    exp_rd(3, 32'h00012345, "R10 unmapped write leaves bank2");
    exp_rd(7, 0, "R10 unmapped read zero");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule